// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

This block is a free-running up-counter with a set of output-compare channels. The counter moves forward by one on each cycle where a count-enable strobe is high. Each channel holds a compare value. When the counter equals that value, the channel's output pin is driven to a level chosen in a control register, and a sticky flag is raised. The pin changes on the clock edge after the match. The change is a driven level, not a toggle.

Channel A can also send the counter back to zero on a match. Software then gets a programmable period of (compare A + 1) counts. Software reaches the counter, the compare values, the control bits and the flags through a single-cycle write port and a combinational read port that share one address.

Top module: `oc_timer`

## Requirements
- R1: After reset the counter reads 0, both compare registers read all ones, the control register reads 0, both flags are 0 and both output pins are low.
- R2: With no write and no clear, the counter advances by one on every clock edge where `cnt_en` is high, wraps from all ones to zero, and holds where `cnt_en` is low.
- R3: While the counter equals compare value i, the next clock edge drives `oc_pin[i]` to control bit i (bit 0 for A, bit 1 for B). In cycles without a match the pin keeps its level, even if the control bit changes.
- R4: A match on channel i sets `match_flag[i]` at the next edge. The flag stays set until a write to the flag register with data bit i equal to 0. Writing 1 to bit i leaves it unchanged. A match and a clearing write in the same cycle leave the flag set.
- R5: When control bit 2 (clear-on-A) is 1 and the counter equals compare A, the next edge loads 0 into the counter. This happens whatever the state of `cnt_en`. With `cnt_en` held high the counter then repeats with period compare A + 1.
- R6: A write to the counter address loads `wdata` at the next edge. This load takes priority over both counting and the clear-on-A load in the same cycle.
- R7: Register map by address: 0 counter, 1 compare A, 2 compare B, 3 control (bit 0 level A, bit 1 level B, bit 2 clear-on-A), 4 flags (bit 0 A, bit 1 B). Reads are combinational. Addresses 5 to 7 read as 0, and writes to them change no register.
- R8: A match on compare B never clears the counter, whatever the clear-on-A bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count-enable strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| oc_pin | output | 2 | Output-compare pins, bit 0 channel A |
| match_flag | output | 2 | Sticky match flags, bit 0 channel A |

## Verification
A counter write and a clear-on-A load can land in the same cycle. The bench provokes this by stalling the counter on compare A with clearing enabled, then writing a new count with `cnt_en` high. It judges the result by reading back the written value rather than zero. A flag-clearing write can also coincide with a live match. The bench provokes this by parking the counter on compare B and writing 0 to the flags, and it expects the flag to read back as 1. Exhaustive period sweeps over every compare A value of an 8-bit build check the clear path against N mod (A + 1).

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

    // Operation the counter applies at the next edge, in priority order.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_STEP = 2'd1,
        CNT_ZERO = 2'd2,
        CNT_LOAD = 2'd3
    } cnt_op_e;

    // Address of the compare register for channel ch.
    function automatic int unsigned cmp_slot(int unsigned ch);
        return ch + 1;
    endfunction

endpackage

// File: rtl/oc_timer_cnt.sv
module oc_timer_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         zero_req,
    output logic [W-1:0] cnt_o
);
    import oc_timer_pkg::*;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    cnt_op_e op;

    always_comb begin
        if (load_en)       op = CNT_LOAD;
        else if (zero_req) op = CNT_ZERO;
        else if (step_en)  op = CNT_STEP;
        else               op = CNT_HOLD;

        st_d = st_q;
        case (op)
            CNT_LOAD: st_d.cnt = load_val;
            CNT_ZERO: st_d.cnt = '0;
            CNT_STEP: st_d.cnt = st_q.cnt + 1'b1;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cnt_o == $past(load_val)); // R6
    AST_ZERO_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && zero_req) |=> cnt_o == '0); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !zero_req && step_en) |=> cnt_o == W'($past(cnt_o) + 1'b1)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !zero_req && !step_en) |=> $stable(cnt_o)); // R2

endmodule

// File: rtl/oc_timer_chan.sv
module oc_timer_chan #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wval,
    input  logic [W-1:0] cnt_i,
    input  logic         level_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] cmp_o,
    output logic         match_o,
    output logic         pin_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic         pin;
        logic         flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        hit  = (cnt_i == st_q.cmp);
        st_d = st_q;
        if (cmp_we) st_d.cmp = cmp_wval;
        if (hit)    st_d.pin = level_i;
        // a live match outranks a clearing write
        if (hit)             st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp  <= '1;
            st_q.pin  <= 1'b0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o   = st_q.cmp;
    assign match_o = hit;
    assign pin_o   = st_q.pin;
    assign flag_o  = st_q.flag;

    AST_PIN_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == cmp_o) |=> pin_o == $past(level_i)); // R3
    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != cmp_o) |=> $stable(pin_o)); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == cmp_o) |=> flag_o); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != cmp_o && !flag_clr_i) |=> $stable(flag_o)); // R4
    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> cmp_o == $past(cmp_wval)); // R7

endmodule

// File: rtl/oc_timer_ctrl.sv
module oc_timer_ctrl #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [NCH:0]   wval,
    output logic [NCH-1:0] level_o,
    output logic           clr_en_o
);
    typedef struct packed {
        logic           clr_en;
        logic [NCH-1:0] level;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.level  = wval[NCH-1:0];
            st_d.clr_en = wval[NCH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o  = st_q.level;
    assign clr_en_o = st_q.clr_en;

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(level_o) && $stable(clr_en_o))); // R7

endmodule

// File: rtl/oc_timer.sv
module oc_timer #(
    parameter int unsigned W   = 16,
    parameter int unsigned NCH = 2,
    parameter int unsigned AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   rdata,
    output logic [NCH-1:0] oc_pin,
    output logic [NCH-1:0] match_flag
);
    import oc_timer_pkg::*;

    localparam int unsigned A_CNT  = 0;
    localparam int unsigned A_CTRL = NCH + 1;
    localparam int unsigned A_FLAG = NCH + 2;

    logic [W-1:0]   cnt;
    logic [W-1:0]   cmp_v [NCH];
    logic [NCH-1:0] match;
    logic [NCH-1:0] level;
    logic           clr_en;
    logic           wr_cnt, wr_ctrl, wr_flag;

    assign wr_cnt  = wr_en && (addr == AW'(A_CNT));
    assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
    assign wr_flag = wr_en && (addr == AW'(A_FLAG));

    oc_timer_cnt #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (cnt_en),
        .load_en  (wr_cnt),
        .load_val (wdata),
        .zero_req (clr_en && match[0]),
        .cnt_o    (cnt)
    );

    oc_timer_ctrl #(.NCH(NCH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_ctrl),
        .wval     (wdata[NCH:0]),
        .level_o  (level),
        .clr_en_o (clr_en)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        oc_timer_chan #(.W(W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmp_we     (wr_en && (addr == AW'(cmp_slot(ch)))),
            .cmp_wval   (wdata),
            .cnt_i      (cnt),
            .level_i    (level[ch]),
            .flag_clr_i (wr_flag && !wdata[ch]),
            .cmp_o      (cmp_v[ch]),
            .match_o    (match[ch]),
            .pin_o      (oc_pin[ch]),
            .flag_o     (match_flag[ch])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_CNT))  rdata = cnt;
        if (addr == AW'(A_CTRL)) rdata[NCH:0] = {clr_en, level};
        if (addr == AW'(A_FLAG)) rdata[NCH-1:0] = match_flag;
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr == AW'(cmp_slot(ch))) rdata = cmp_v[ch];
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) > int'(A_FLAG)) |-> rdata == '0); // R7
    AST_CLEAR_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && match[0] && !wr_cnt) |=> cnt == '0); // R5
    AST_B_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (match[NCH-1] && !match[0] && !wr_cnt && cnt_en) |=> cnt == W'($past(cnt) + 1'b1)); // R8

endmodule

// File: tb/oc_timer_bench.sv
`timescale 1ns/1ps
module oc_timer_bench;
    localparam int W   = 8;
    localparam int NCH = 2;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n, cnt_en, wr_en;
    logic [AW-1:0]  addr;
    logic [W-1:0]   wdata, rdata;
    logic [NCH-1:0] oc_pin, match_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    oc_timer #(.W(W), .NCH(NCH), .AW(AW)) u_oc_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .oc_pin(oc_pin), .match_flag(match_flag)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(int a, int d);
        wr_en = 1'b1; addr = AW'(a); wdata = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [W-1:0] v);
        addr = AW'(a);
        #1;
        v = rdata;
    endtask

    task automatic run(int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R2 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [1:0]   exp_pin;
        int           vals [4] = '{3, 60, 129, 254};
        rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        exp_pin = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 counter", v, 8'h00);
        rd(1, v); chk("R1 compare A", v, 8'hFF);
        rd(2, v); chk("R1 compare B", v, 8'hFF);
        rd(3, v); chk("R1 control", v, 8'h00);
        rd(4, v); chk("R1 flags", v, 8'h00);
        chk("R1 pins", W'(oc_pin), 8'h00);

        // R2 counting, wrap and hold
        wr(3, 0);
        for (int s = 0; s < 256; s += 5) begin
            int k = (s * 7) % 40 + 1;
            wr(0, s);
            run(k);
            rd(0, v); chk("R2 count", v, W'((s + k) % 256));
            repeat (3) @(negedge clk);
            rd(0, v); chk("R2 hold", v, W'((s + k) % 256));
        end

        // R3/R4 pin level, one-edge latency, hold; flag set
        for (int ch = 0; ch < NCH; ch++) begin
            for (int i = 0; i < 4; i++) begin
                int c  = vals[i];
                int lv = (i + 1) % 2;
                wr(0, (c + 1) % 256);
                wr(1 + ch, c);
                wr(1 + (1 - ch), (c + 128) % 256);
                wr(3, lv << ch);
                wr(4, 0);
                chk("R3 pin before match", W'(oc_pin[ch]), W'(exp_pin[ch]));
                wr(0, c);
                chk("R3 pin not yet changed", W'(oc_pin[ch]), W'(exp_pin[ch]));
                @(negedge clk);
                chk("R3 pin takes level", W'(oc_pin[ch]), W'(lv));
                exp_pin[ch] = lv[0];
                rd(4, v); chk("R4 flag set on match", W'(v[ch]), 8'h01);
                wr(0, (c + 1) % 256);
                wr(3, (1 - lv) << ch);
                repeat (2) @(negedge clk);
                chk("R3 pin holds without match", W'(oc_pin[ch]), W'(lv));
            end
        end

        // R4 set beats clear, write 1 keeps, write 0 clears
        wr(3, 0);
        wr(1, 200);
        wr(2, 90);
        wr(0, 90);
        @(negedge clk);
        wr(4, 0);
        rd(4, v); chk("R4 match beats clear", W'(v[1]), 8'h01);
        wr(0, 91);
        wr(4, 8'hFE);
        rd(4, v); chk("R4 write one keeps flag", W'(v[1]), 8'h01);
        wr(4, 0);
        rd(4, v); chk("R4 write zero clears", W'(v[1]), 8'h00);

        // R8 match B does not clear
        wr(3, 4);
        wr(1, 200);
        wr(2, 10);
        wr(0, 5);
        run(10);
        rd(0, v); chk("R8 counter past B", v, 8'd15);
        rd(4, v); chk("R8 flag B seen", W'(v[1]), 8'h01);

        // R6 counter write beats clear-on-A and counting
        wr(1, 40);
        wr(0, 40);
        cnt_en = 1'b1;
        wr(0, 77);
        cnt_en = 1'b0;
        rd(0, v); chk("R6 write wins", v, 8'd77);

        // R5 clear on stalled match A
        wr(0, 40);
        @(negedge clk);
        rd(0, v); chk("R5 clear while stalled", v, 8'd0);

        // R5 period sweep over every compare A value
        for (int p = 0; p < 256; p++) begin
            int n = 2 * p + 7;
            wr(3, 4);
            wr(1, p);
            wr(0, 0);
            run(n);
            rd(0, v); chk("R5 period", v, W'(n % (p + 1)));
        end

        // R7 unmapped addresses
        wr(3, 3);
        wr(1, 8'h21);
        wr(2, 8'h42);
        wr(0, 8'h63);
        wr(5, 8'hAB);
        wr(6, 8'hCD);
        wr(7, 8'hEF);
        for (int a = 5; a < 8; a++) begin
            rd(a, v); chk("R7 unmapped reads zero", v, 8'h00);
        end
        rd(0, v); chk("R7 counter untouched", v, 8'h63);
        rd(1, v); chk("R7 compare A untouched", v, 8'h21);
        rd(2, v); chk("R7 compare B untouched", v, 8'h42);
        rd(3, v); chk("R7 control untouched", v, 8'h03);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule